// File: doc/BRIEF.md
# Bus Hold Request/Grant Handshake

This block connects a level-signalled bus hold request to a processor that arbitrates its bus over a single open-drain request/grant pin carrying short low pulses. A bus master raises the hold request and keeps it high. The block synchronises the request on the falling processor clock edge. It then pulls the shared pin low for one clock as a request. It watches the pin for the processor's grant pulse and raises the hold acknowledge when the grant arrives. The acknowledge stays high for as long as the master keeps the request. When the master drops the request, the block pulls the pin low for one more clock to hand the bus back, and then lowers the acknowledge.

The pin is modelled as a sensed level (`rgPinIn`, low while anyone pulls it down) plus a pull-down enable (`rgPullLow`). The block never drives the pin high. It does not pull it while the processor's grant pulse is on the pin. Pin activity that does not answer one of the block's own requests has no effect. After each release there is a minimum idle spacing before a new request can start.

Top module: `hold_hs_top`

## Requirements
- R1: A change on `holdReq` made after rising edge c reaches the control at rising edge c+SYNC_STAGES, through SYNC_STAGES flops clocked on the falling edge. With the block idle and the pin high, the request pulse starts at that edge.
- R2: With the block idle, the synchronised request active and `rgPinIn`=1 sampled at a rising edge, `rgPullLow` goes to 1 at that edge for exactly one clock. While the pin is sensed low, the request is held back.
- R3: After its request pulse, the first rising edge at which `rgPinIn`=0 is sampled counts as the grant, and `holdAck` rises at that edge.
- R4: `rgPullLow` stays 0 from the end of the request pulse until the grant has ended. Pin low pulses while the block is idle leave both outputs at 0.
- R5: `holdAck` stays 1 for as long as the synchronised request stays active.
- R6: While acknowledged, the first rising edge with the synchronised request inactive and `rgPinIn`=1 starts a release pulse: `rgPullLow`=1 for exactly one clock.
- R7: `holdAck` falls one clock after the release pulse ends, that is, two edges after the release pulse starts.
- R8: After `holdAck` falls, MIN_IDLE clocks pass in which a request is ignored. The earliest new request pulse starts MIN_IDLE+1 edges after the fall, even if `holdReq` is already high.
- R9: If `holdReq` drops before the grant arrives, the block still waits for the grant, raises `holdAck`, and then releases as in R6 and R7.
- R10: While `rstN` is low, `rgPullLow` and `holdAck` are 0 and the block returns to idle. This also applies when reset is asserted in the middle of a hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous active-low reset |
| holdReq | input | 1 | Asynchronous level bus hold request from a master |
| rgPinIn | input | 1 | Sensed level of the open-drain request/grant pin (0 = pulled low) |
| rgPullLow | output | 1 | 1 pulls the request/grant pin low |
| holdAck | output | 1 | Bus hold acknowledge |

## Verification
The assertions check on every cycle that each pull-down pulse lasts exactly one clock. They also check that a pull starts only on a pin sensed high. They check that a request pulse follows an active synchronised request and a release pulse follows an inactive one. Finally, they check that the acknowledge rises only on a sensed grant and falls only two clocks after a release pulse began. The bench scenarios cover the absolute timing of each event through the synchroniser, the processor's grant pulse of varying delay and width, and a request dropped before its grant. They also cover a request raised again during the release, stray pin pulses, a busy pin at request time, and reset in the middle of a hold.

// File: rtl/hold_hs_pkg.sv
package hold_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_HOLD,
    ST_REL,
    ST_END,
    ST_GAP
  } hsState_t;

  // Strobes from the control to the datapath registers.
  typedef struct packed {
    logic pullSet;
    logic pullClr;
    logic ackSet;
    logic ackClr;
    logic gapLoad;
  } hsStrobe_t;

endpackage

// File: rtl/hold_hs_datapath.sv
module hold_hs_datapath
  import hold_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_IDLE    = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      holdReq,
  input  logic      rgPinIn,
  input  hsStrobe_t strobe,
  output logic      holdSync,
  output logic      pinHigh,
  output logic      gapDone,
  output logic      rgPullLow,
  output logic      holdAck
);

  localparam int CNT_W = (MIN_IDLE > 1) ? $clog2(MIN_IDLE) : 1;

  // Falling-edge synchroniser for the asynchronous hold request
  logic [SYNC_STAGES-1:0] syncQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= holdReq;
      end
    end else begin : g_sync_chain
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], holdReq};
      end
    end
  endgenerate

  assign holdSync = syncQ[SYNC_STAGES-1];
  assign pinHigh  = rgPinIn;

  // Pin pull-down enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rgPullLow <= 1'b0;
    else if (strobe.pullSet)  rgPullLow <= 1'b1;
    else if (strobe.pullClr)  rgPullLow <= 1'b0;
  end

  // Hold acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdAck <= 1'b0;
    else if (strobe.ackSet)  holdAck <= 1'b1;
    else if (strobe.ackClr)  holdAck <= 1'b0;
  end

  // Idle spacing counter
  logic [CNT_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                gapCnt <= '0;
    else if (strobe.gapLoad)  gapCnt <= CNT_W'(MIN_IDLE - 1);
    else if (gapCnt != '0)    gapCnt <= gapCnt - 1'b1;
  end

  assign gapDone = (gapCnt == '0);

  // Every pull-down pulse lasts exactly one clock (R2, R6)
  p_pull_single_clock_r2: assert property (@(posedge clk) disable iff (!rstN)
    rgPullLow |=> !rgPullLow);

  // The pin is pulled only after it was sensed free (R4)
  p_pull_needs_free_pin_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rgPullLow) |-> $past(rgPinIn));

  // A request pulse follows an active synchronised request (R1)
  p_request_after_sync_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rgPullLow) && !holdAck) |-> $past(holdSync));

  // A release pulse follows an inactive synchronised request (R6)
  p_release_after_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rgPullLow) && holdAck) |-> !$past(holdSync));

  // Acknowledge rises only on a sensed grant (R3)
  p_ack_after_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> !$past(rgPinIn));

  // Acknowledge falls one clock after the release pulse ends (R7)
  p_ack_drop_after_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdAck) |-> (!$past(rgPullLow) && $past(rgPullLow, 2)));

endmodule

// File: rtl/hold_hs_ctrl.sv
module hold_hs_ctrl
  import hold_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      holdSync,
  input  logic      pinHigh,
  input  logic      gapDone,
  output hsStrobe_t strobe
);

  hsState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        // Pin activity here is not an answer to anything: ignored
        if (holdSync && pinHigh) begin
          strobe.pullSet = 1'b1;
          stateNext      = ST_REQ;
        end
      end
      ST_REQ: begin
        strobe.pullClr = 1'b1;
        stateNext      = ST_WAIT;
      end
      ST_WAIT: begin
        if (!pinHigh) begin
          strobe.ackSet = 1'b1;
          stateNext     = ST_HOLD;
        end
      end
      ST_HOLD: begin
        // Release waits for the grant pulse to have left the pin
        if (!holdSync && pinHigh) begin
          strobe.pullSet = 1'b1;
          stateNext      = ST_REL;
        end
      end
      ST_REL: begin
        strobe.pullClr = 1'b1;
        stateNext      = ST_END;
      end
      ST_END: begin
        strobe.ackClr  = 1'b1;
        strobe.gapLoad = 1'b1;
        stateNext      = ST_GAP;
      end
      ST_GAP: begin
        if (gapDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // No request leaves the idle spacing early (R8)
  p_gap_before_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && !gapDone) |=> (state == ST_GAP));

endmodule

// File: rtl/hold_hs_top.sv
module hold_hs_top
  import hold_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_IDLE    = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic holdReq,
  input  logic rgPinIn,
  output logic rgPullLow,
  output logic holdAck
);

  hsStrobe_t strobe;
  logic      holdSync;
  logic      pinHigh;
  logic      gapDone;

  hold_hs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .holdSync (holdSync),
    .pinHigh  (pinHigh),
    .gapDone  (gapDone),
    .strobe   (strobe)
  );

  hold_hs_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_IDLE    (MIN_IDLE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .holdReq   (holdReq),
    .rgPinIn   (rgPinIn),
    .strobe    (strobe),
    .holdSync  (holdSync),
    .pinHigh   (pinHigh),
    .gapDone   (gapDone),
    .rgPullLow (rgPullLow),
    .holdAck   (holdAck)
  );

endmodule

// File: tb/tb_hold_hs_top.sv
module tb_hold_hs_top;

  localparam int SYNC_STAGES = 2;
  localparam int MIN_IDLE    = 1;
  localparam int EV_PR = 0, EV_PF = 1, EV_AR = 2, EV_AF = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdReq = 1'b0;
  logic cpuLow = 1'b0;
  logic rgPinIn;
  logic rgPullLow;
  logic holdAck;

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  monOn = 1'b1;
  bit  done = 1'b0;

  int    expKind[$];
  int    expCyc[$];
  string expTag[$];

  // Wired-AND open-drain pin with the processor model
  assign rgPinIn = !(rgPullLow || cpuLow);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hold_hs_top #(.SYNC_STAGES(SYNC_STAGES), .MIN_IDLE(MIN_IDLE)) dut (
    .clk(clk), .rstN(rstN), .holdReq(holdReq), .rgPinIn(rgPinIn),
    .rgPullLow(rgPullLow), .holdAck(holdAck)
  );

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void pushExp(input int k, input int c, input string t);
    expKind.push_back(k);
    expCyc.push_back(c);
    expTag.push_back(t);
  endfunction

  task automatic seen(input int k);
    int ek, ec;
    string et;
    if (expKind.size() == 0) begin
      chk(1'b0, "R4", "unexpected output event kind", k, -1);
    end else begin
      ek = expKind.pop_front();
      ec = expCyc.pop_front();
      et = expTag.pop_front();
      chk(ek == k, et, "event kind", k, ek);
      chk(ec == cyc, et, "event cycle", cyc, ec);
    end
  endtask

  // Monitor: pops the scoreboard on every output change
  initial begin
    logic pp, pa;
    pp = 1'b0;
    pa = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      if (monOn) begin
        if (rgPullLow !== pp) seen(rgPullLow ? EV_PR : EV_PF);
        if (holdAck !== pa)   seen(holdAck ? EV_AR : EV_AF);
      end
      pp = rgPullLow;
      pa = holdAck;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // One full hold cycle with a processor grant of delay d and width w.
  // dropDelta places the request drop relative to the request pulse edge.
  task automatic runCycle(input int raiseAt, input int allowAt, input int d,
                          input int w, input int dropDelta, input bit doReRaise,
                          input int strayClrAt, input string ackTag,
                          output int nextAllow, output int reRaiseAt);
    int p, g, h, r0, rr;
    string firstTag;
    p = raiseAt + SYNC_STAGES;
    firstTag = "R1";
    if (strayClrAt >= 0 && strayClrAt + 1 > p) begin
      p = strayClrAt + 1;
      firstTag = "R2";
    end
    if (allowAt > p) begin
      p = allowAt;
      firstTag = "R8";
    end
    g  = p + 1 + d;
    h  = p + dropDelta;
    r0 = imax(h + SYNC_STAGES, g + w + 1);
    rr = doReRaise ? r0 - 1 : -100;
    pushExp(EV_PR, p, firstTag);
    pushExp(EV_PF, p + 1, "R2");
    pushExp(EV_AR, g + 1, ackTag);
    pushExp(EV_PR, r0, "R6");
    pushExp(EV_PF, r0 + 1, "R6");
    pushExp(EV_AF, r0 + 2, "R7");
    forever begin
      if (cyc == raiseAt) holdReq = 1'b1;
      if (cyc == strayClrAt) cpuLow = 1'b0;
      if (cyc == g) begin
        chk(rgPullLow == 1'b0, "R4", "pin pulled during grant", rgPullLow, 0);
        cpuLow = 1'b1;
      end
      if (cyc == g + w) cpuLow = 1'b0;
      if (cyc == h) holdReq = 1'b0;
      if (cyc == rr) holdReq = 1'b1;
      if (cyc == r0 - 1)
        chk(holdAck == 1'b1, "R5", "acknowledge held", holdAck, 1);
      if (cyc >= r0 + 2) break;
      step(1);
    end
    nextAllow = r0 + 3 + MIN_IDLE;
    reRaiseAt = rr;
  endtask

  initial begin
    int na, rr, dummy;
    // R10: reset state
    step(3);
    chk(rgPullLow == 1'b0, "R10", "pull in reset", rgPullLow, 0);
    chk(holdAck == 1'b0, "R10", "ack in reset", holdAck, 0);
    rstN = 1'b1;
    step(3);

    // Plain hold with delayed grant, long hold (R1 R3 R5 R6 R7)
    runCycle(cyc + 1, 0, 2, 1, 6, 1'b0, -1, "R3", na, dummy);
    step(4);

    // Long grant pulse, request dropped right after: release waits for pin (R4 R6)
    runCycle(cyc + 1, 0, 0, 4, 1, 1'b0, -1, "R3", na, dummy);
    step(4);

    // R9: request dropped before the grant arrives
    runCycle(cyc + 1, 0, 3, 1, -1, 1'b0, -1, "R9", na, dummy);
    step(4);

    // R8: request raised again during the release, held off by idle spacing
    runCycle(cyc + 1, 0, 1, 1, 3, 1'b1, -1, "R3", na, rr);
    runCycle(rr, na, 1, 2, 4, 1'b0, -1, "R3", na, dummy);
    step(4);

    // R4: stray pin pulses while idle have no effect
    cpuLow = 1'b1;
    step(3);
    cpuLow = 1'b0;
    step(3);
    chk(rgPullLow == 1'b0, "R4", "pull after stray pulse", rgPullLow, 0);
    chk(holdAck == 1'b0, "R4", "ack after stray pulse", holdAck, 0);

    // R2: request held back while the pin is busy
    cpuLow = 1'b1;
    runCycle(cyc + 1, 0, 1, 1, 2, 1'b0, cyc + 4, "R3", na, dummy);
    step(4);

    // R10: reset in the middle of a hold
    monOn = 1'b0;
    holdReq = 1'b1;
    step(SYNC_STAGES + 2);
    cpuLow = 1'b1;
    step(1);
    cpuLow = 1'b0;
    step(2);
    chk(holdAck == 1'b1, "R3", "ack before mid-hold reset", holdAck, 1);
    rstN = 1'b0;
    #1;
    chk(rgPullLow == 1'b0, "R10", "pull at mid-hold reset", rgPullLow, 0);
    chk(holdAck == 1'b0, "R10", "ack at mid-hold reset", holdAck, 0);
    holdReq = 1'b0;
    step(2);
    rstN = 1'b1;
    step(4);
    chk(rgPullLow == 1'b0, "R10", "pull idle after reset", rgPullLow, 0);
    chk(holdAck == 1'b0, "R10", "ack idle after reset", holdAck, 0);
    monOn = 1'b1;

    // Back to normal operation after reset
    runCycle(cyc + 1, 0, 0, 1, 3, 1'b0, -1, "R3", na, dummy);
    step(5);

    while (expKind.size() != 0) begin
      chk(1'b0, expTag.pop_front(), "missing event kind", -1, expKind.pop_front());
      void'(expCyc.pop_front());
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule